// File: doc/BRIEF.md
# Dual-Host Three-Bank Flash Read Router

This block sits between two 32-bit read hosts and three flash banks that each return a 128-bit line. It decodes every host address into a bank and a line within that bank. It then forwards the request to that bank's 128-bit handshake and sends back the addressed 32-bit word to the host that asked for it. Two hosts that target different banks are served side by side in the same cycle. Two hosts that target the same bank are ordered by a per-bank round-robin, and the losing host is held off with its ready low.

The address space is 16 MB and the split is uneven. Two 4 MB code banks take the lower half, and one 8 MB data bank takes the upper half. The data bank can be left out at build time. In that case any read in its range is accepted and answered with an error. Each host request channel is valid/ready: a host holds valid and address stable until it sees ready high at a clock edge. Each host may have one read outstanding. Responses carry no ready: the host must take the response in the cycle it is shown. Bank request channels are valid/ready. Bank responses are a single-cycle valid with no back-pressure.

Top module: `flash_xbar`

## Requirements
- R1: While reset is asserted and after its release, no host response valid and no bank request valid is driven until a request arrives.
- R2: Address bits [23:22] select the bank: 00 selects code bank 0 (0x000000–0x3FFFFF), 01 selects code bank 2 (0x400000–0x7FFFFF), and 1x selects data bank 1 (0x800000–0xFFFFFF). The line sent to the bank is the byte offset from the bank's base divided by 16.
- R3: Two requests to different banks are both accepted at the same clock edge and both complete in the same number of cycles as a lone request.
- R4: When both hosts target the same bank, only one is granted. The other's ready stays low until that bank's grant is released, and it is accepted exactly the bank latency plus two cycles after the first.
- R5: Each bank starts with host 0 preferred. After every grant on a bank, preference on that bank passes to the host that was not granted.
- R6: A grant is held until the bank returns its response valid. A bank request valid that meets ready low stays high with its line unchanged.
- R7: Bank response data goes only to the host that owns that bank's grant. That host receives bits [32k+31:32k] of the line, where k is address bits [3:2].
- R8: A host with a read outstanding sees ready low until its response has been shown.
- R9: With the data bank configured absent, a read in its range is accepted at once. Exactly one cycle later it is answered with error high and data zero, and no request reaches bank 1.
- R10: The host response valid is high in the same cycle as the bank response valid. With an always-ready bank of latency L, a response appears L clock edges after the edge that accepted the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req_valid | input | 2 | Per-host read request valid |
| host_req_ready | output | 2 | Per-host request accepted this edge |
| host_req_addr | input | 2x24 | Per-host byte address |
| host_rsp_valid | output | 2 | Per-host response valid, one cycle |
| host_rsp_data | output | 2x32 | Per-host read word |
| host_rsp_err | output | 2 | Per-host error flag (absent bank) |
| bank_req_valid | output | 3 | Per-bank line request valid |
| bank_req_ready | input | 3 | Per-bank line request ready |
| bank_req_line | output | 3x19 | Per-bank line index within the bank |
| bank_rsp_valid | input | 3 | Per-bank line return valid, one cycle |
| bank_rsp_data | input | 3x128 | Per-bank returned line |

## Verification
The bench builds the block twice with the default 22-bit code bank offset: once with the data bank present and once with it absent. The second copy receives the same host stimulus. With the small two-host, three-bank shape, every pairing of target regions can be swept, including each single-host case, for all four word positions and at both region edges. This reaches every same-bank contention and every round-robin pointer state. The absent copy brings the error path and the silence of bank 1 within reach. Bank models with a fixed latency, and an optional ready stall, make the expected acceptance edge, latency and returned word computable in closed form.

// File: rtl/flash_xbar_pkg.sv
package flash_xbar_pkg;
  localparam int unsigned N_HOST = 2;
  localparam int unsigned N_BANK = 3;

  // Enum value equals the bank port index it selects.
  typedef enum logic [1:0] {
    BK_CODE_LO = 2'd0,
    BK_DATA    = 2'd1,
    BK_CODE_HI = 2'd2
  } bank_sel_e;
endpackage

// File: rtl/fx_addr_decode.sv
module fx_addr_decode
  import flash_xbar_pkg::*;
#(
  parameter int unsigned CODE_W = 22,
  parameter int unsigned OFF_W  = 4,
  parameter int unsigned WSEL_W = 2,
  localparam int unsigned ADDR_W = CODE_W + 2,
  localparam int unsigned LINE_W = CODE_W + 1 - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  output bank_sel_e         sel,
  output logic [LINE_W-1:0] line,
  output logic [WSEL_W-1:0] wsel
);
  logic unused_lsb;
  assign unused_lsb = ^addr[OFF_W-WSEL_W-1:0];

  always_comb begin
    if (addr[ADDR_W-1]) begin
      // upper half: the larger data bank
      sel  = BK_DATA;
      line = addr[ADDR_W-2:OFF_W];
    end else begin
      sel  = addr[ADDR_W-2] ? BK_CODE_HI : BK_CODE_LO;
      line = {1'b0, addr[CODE_W-1:OFF_W]};
    end
    wsel = addr[OFF_W-1 -: WSEL_W];
  end
endmodule

// File: rtl/fx_bank_arb.sv
module fx_bank_arb
  import flash_xbar_pkg::*;
#(
  parameter int unsigned LINE_W    = 19,
  parameter int unsigned WSEL_W    = 2,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LINE_BITS = 128
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_HOST-1:0]             req,
  input  logic [N_HOST-1:0][LINE_W-1:0] line_in,
  input  logic [N_HOST-1:0][WSEL_W-1:0] wsel_in,
  output logic [N_HOST-1:0]             gnt,
  output logic                          bk_req_valid,
  input  logic                          bk_req_ready,
  output logic [LINE_W-1:0]             bk_req_line,
  input  logic                          bk_rsp_valid,
  input  logic [LINE_BITS-1:0]          bk_rsp_data,
  output logic [N_HOST-1:0]             rsp_hit,
  output logic [DATA_W-1:0]             rsp_word
);
  logic              busy_q, sent_q, owner_q, ptr_q, win;
  logic [LINE_W-1:0] line_q;
  logic [WSEL_W-1:0] wsel_q;
  logic              done;

  // round-robin pick: pointer decides only on contention
  always_comb begin
    win = (req == 2'b11) ? ptr_q : req[1];
    gnt = '0;
    if (!busy_q && (req != '0)) gnt[win] = 1'b1;
  end

  assign done = busy_q && sent_q && bk_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sent_q  <= 1'b0;
      owner_q <= 1'b0;
      ptr_q   <= 1'b0;
      line_q  <= '0;
      wsel_q  <= '0;
    end else if (gnt != '0) begin
      busy_q  <= 1'b1;
      sent_q  <= 1'b0;
      owner_q <= win;
      ptr_q   <= ~win;
      line_q  <= line_in[win];
      wsel_q  <= wsel_in[win];
    end else if (busy_q) begin
      if (bk_req_valid && bk_req_ready) sent_q <= 1'b1;
      if (done) busy_q <= 1'b0;
    end
  end

  assign bk_req_valid = busy_q && !sent_q;
  assign bk_req_line  = line_q;

  always_comb begin
    rsp_hit = '0;
    if (done) rsp_hit[owner_q] = 1'b1;
    rsp_word = bk_rsp_data[wsel_q*DATA_W +: DATA_W];
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R4
  AST_BANK_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bk_req_valid && !bk_req_ready |=> bk_req_valid && $stable(bk_req_line)); // R6
  AST_OWNER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !done |=> busy_q && $stable(owner_q)); // R6
endmodule

// File: rtl/fx_host_port.sv
module fx_host_port
  import flash_xbar_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          absent_hit,
  input  logic                          bank_accept,
  input  logic [N_BANK-1:0]             bank_hit,
  input  logic [N_BANK-1:0][DATA_W-1:0] bank_word,
  output logic                          eligible,
  output logic                          req_ready,
  output logic                          rsp_valid,
  output logic [DATA_W-1:0]             rsp_data,
  output logic                          rsp_err
);
  logic pend_q, err_q;

  assign eligible  = req_valid && !pend_q && !absent_hit;
  assign req_ready = !pend_q && (absent_hit || bank_accept);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= req_valid && !pend_q && absent_hit;
      if (req_valid && req_ready) pend_q <= 1'b1;
      else if (rsp_valid)         pend_q <= 1'b0;
    end
  end

  always_comb begin
    rsp_valid = err_q || (bank_hit != '0);
    rsp_err   = err_q;
    rsp_data  = '0;
    for (int b = 0; b < N_BANK; b++)
      if (bank_hit[b]) rsp_data = rsp_data | bank_word[b];
  end

  AST_RSP_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> pend_q); // R8
  AST_SINGLE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_q, bank_hit})); // R7
  AST_ERR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && absent_hit |=> rsp_valid && rsp_err); // R9
endmodule

// File: rtl/flash_xbar.sv
module flash_xbar
  import flash_xbar_pkg::*;
#(
  parameter int unsigned CODE_W        = 22,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned LINE_BITS     = 128,
  parameter bit          HAS_DATA_BANK = 1'b1,
  localparam int unsigned ADDR_W = CODE_W + 2,
  localparam int unsigned OFF_W  = $clog2(LINE_BITS / 8),
  localparam int unsigned BYTE_W = $clog2(DATA_W / 8),
  localparam int unsigned WSEL_W = OFF_W - BYTE_W,
  localparam int unsigned LINE_W = CODE_W + 1 - OFF_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [N_HOST-1:0]                host_req_valid,
  output logic [N_HOST-1:0]                host_req_ready,
  input  logic [N_HOST-1:0][ADDR_W-1:0]    host_req_addr,
  output logic [N_HOST-1:0]                host_rsp_valid,
  output logic [N_HOST-1:0][DATA_W-1:0]    host_rsp_data,
  output logic [N_HOST-1:0]                host_rsp_err,
  output logic [N_BANK-1:0]                bank_req_valid,
  input  logic [N_BANK-1:0]                bank_req_ready,
  output logic [N_BANK-1:0][LINE_W-1:0]    bank_req_line,
  input  logic [N_BANK-1:0]                bank_rsp_valid,
  input  logic [N_BANK-1:0][LINE_BITS-1:0] bank_rsp_data
);
  bank_sel_e                          sel [N_HOST];
  logic [N_HOST-1:0][LINE_W-1:0]      line;
  logic [N_HOST-1:0][WSEL_W-1:0]      wsel;
  logic [N_HOST-1:0]                  elig, absent, accept;
  logic [N_BANK-1:0][N_HOST-1:0]      breq, gnt, hit;
  logic [N_HOST-1:0][N_BANK-1:0]      hit_t;
  logic [N_BANK-1:0][DATA_W-1:0]      word;

  for (genvar p = 0; p < N_HOST; p++) begin : g_dec
    fx_addr_decode #(.CODE_W(CODE_W), .OFF_W(OFF_W), .WSEL_W(WSEL_W)) u_dec (
      .addr (host_req_addr[p]),
      .sel  (sel[p]),
      .line (line[p]),
      .wsel (wsel[p])
    );
    assign absent[p] = !HAS_DATA_BANK && (sel[p] == BK_DATA);
  end

  // request matrix and its transposes
  always_comb begin
    for (int b = 0; b < N_BANK; b++)
      for (int p = 0; p < N_HOST; p++) begin
        breq[b][p]  = elig[p] && (sel[p] == bank_sel_e'(b));
        hit_t[p][b] = hit[b][p];
      end
    for (int p = 0; p < N_HOST; p++) begin
      accept[p] = 1'b0;
      for (int b = 0; b < N_BANK; b++) accept[p] = accept[p] | gnt[b][p];
    end
  end

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    if (b == int'(BK_DATA) && !HAS_DATA_BANK) begin : g_absent
      logic unused_absent;
      assign unused_absent     = ^{bank_req_ready[b], bank_rsp_valid[b], bank_rsp_data[b], breq[b]};
      assign gnt[b]            = '0;
      assign hit[b]            = '0;
      assign word[b]           = '0;
      assign bank_req_valid[b] = 1'b0;
      assign bank_req_line[b]  = '0;
    end else begin : g_arb
      fx_bank_arb #(
        .LINE_W(LINE_W), .WSEL_W(WSEL_W), .DATA_W(DATA_W), .LINE_BITS(LINE_BITS)
      ) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (breq[b]),
        .line_in      (line),
        .wsel_in      (wsel),
        .gnt          (gnt[b]),
        .bk_req_valid (bank_req_valid[b]),
        .bk_req_ready (bank_req_ready[b]),
        .bk_req_line  (bank_req_line[b]),
        .bk_rsp_valid (bank_rsp_valid[b]),
        .bk_rsp_data  (bank_rsp_data[b]),
        .rsp_hit      (hit[b]),
        .rsp_word     (word[b])
      );
    end
  end

  for (genvar p = 0; p < N_HOST; p++) begin : g_host
    fx_host_port #(.DATA_W(DATA_W)) u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (host_req_valid[p]),
      .absent_hit  (absent[p]),
      .bank_accept (accept[p]),
      .bank_hit    (hit_t[p]),
      .bank_word   (word),
      .eligible    (elig[p]),
      .req_ready   (host_req_ready[p]),
      .rsp_valid   (host_rsp_valid[p]),
      .rsp_data    (host_rsp_data[p]),
      .rsp_err     (host_rsp_err[p])
    );
  end
endmodule

// File: tb/test_flash_xbar.sv
`timescale 1ns/1ps
module test_flash_xbar;
  localparam int CODE_W = 22;
  localparam int AW     = 24;
  localparam int LW     = 19;
  localparam int DW     = 32;
  localparam int LB     = 128;
  localparam int LAT    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]          hv;
  logic [1:0][AW-1:0]  ha;
  logic [1:0]          hr, rv, re, n_hr, n_rv, n_re;
  logic [1:0][DW-1:0]  rd, n_rd;
  logic [2:0]          bv, brdy, bsv, n_bv;
  logic [2:0][LW-1:0]  bl, n_bl;
  logic [2:0][LB-1:0]  bsd;

  flash_xbar #(.CODE_W(CODE_W), .HAS_DATA_BANK(1'b1)) i_flash_xbar (
    .clk(clk), .rst_n(rst_n),
    .host_req_valid(hv), .host_req_ready(hr), .host_req_addr(ha),
    .host_rsp_valid(rv), .host_rsp_data(rd), .host_rsp_err(re),
    .bank_req_valid(bv), .bank_req_ready(brdy), .bank_req_line(bl),
    .bank_rsp_valid(bsv), .bank_rsp_data(bsd));

  flash_xbar #(.CODE_W(CODE_W), .HAS_DATA_BANK(1'b0)) i_flash_xbar_nodata (
    .clk(clk), .rst_n(rst_n),
    .host_req_valid(hv), .host_req_ready(n_hr), .host_req_addr(ha),
    .host_rsp_valid(n_rv), .host_rsp_data(n_rd), .host_rsp_err(n_re),
    .bank_req_valid(n_bv), .bank_req_ready(brdy), .bank_req_line(n_bl),
    .bank_rsp_valid(bsv), .bank_rsp_data(bsd));

  int vectors = 0, fails = 0, cyc = 0;

  function automatic logic [DW-1:0] mkword(int b, int w, logic [LW-1:0] l);
    return {4'(b), 2'(w), 26'(l)};
  endfunction

  // bank models: fixed latency, optional ready stall
  int cnt [3];
  int stall [3];
  logic [2:0][LW-1:0] mline;
  initial for (int b = 0; b < 3; b++) begin cnt[b] = 0; stall[b] = 0; end
  for (genvar b = 0; b < 3; b++) begin : g_model
    assign brdy[b] = (stall[b] == 0);
    assign bsv[b]  = (cnt[b] == 1);
    always_comb for (int k = 0; k < 4; k++) bsd[b][k*DW +: DW] = mkword(b, k, mline[b]);
    always @(posedge clk) begin
      if (!rst_n) begin
        cnt[b] <= 0; mline[b] <= '0;
      end else begin
        if (bv[b] && brdy[b]) begin cnt[b] <= LAT; mline[b] <= bl[b]; end
        else if (cnt[b] != 0) cnt[b] <= cnt[b] - 1;
        if (bv[b] && stall[b] != 0) stall[b] <= stall[b] - 1;
      end
    end
  end

  // host-side monitor
  int acc_cyc [2];
  int lat [2];
  bit accepted [2];
  bit got [2];
  bit drop [2];
  logic [DW-1:0] gdata [2];
  logic gerr [2];
  int nd_bank1_seen = 0;

  always @(posedge clk) begin
    cyc++;
    #1;
    for (int p = 0; p < 2; p++) if (drop[p]) begin hv[p] = 1'b0; drop[p] = 1'b0; end
  end

  always @(negedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (hv[p] && hr[p] && !drop[p]) begin
        acc_cyc[p] = cyc + 1; accepted[p] = 1'b1; drop[p] = 1'b1;
      end
      if (rv[p]) begin
        got[p] = 1'b1; lat[p] = cyc - acc_cyc[p]; gdata[p] = rd[p]; gerr[p] = re[p];
      end
    end
    if (n_bv[1]) nd_bank1_seen++;
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bank_of(int r); return (r == 0) ? 0 : (r == 1) ? 2 : 1; endfunction
  function automatic int size_of(int r); return (r == 2) ? (1 << 23) : (1 << 22); endfunction

  int ptr [3];

  task automatic wait_got(int mask);
    for (int t = 0; t < 80; t++) begin
      if ((!mask[0] || got[0]) && (!mask[1] || got[1])) return;
      @(negedge clk);
    end
  endtask

  // one sweep point: r=3 means host idle
  task automatic run_case(int r0, int r1, int seed, int w);
    int r [2];
    int off [2];
    int bk [2];
    int mask;
    r[0] = r0; r[1] = r1; mask = 0;
    for (int p = 0; p < 2; p++) begin
      accepted[p] = 0; got[p] = 0;
      if (r[p] != 3) begin
        off[p] = ((seed * 32'h2F1D3 + p * 32'h51A0) & (size_of(r[p]) - 1)) & ~32'hF;
        if ((seed & 3) == 3) off[p] = size_of(r[p]) - 16;
        if ((seed & 3) == 2) off[p] = 0;
        off[p] = off[p] | (w * 4);
        bk[p] = bank_of(r[p]);
        ha[p] = AW'(r[p] * 32'h400000 + off[p]);
        hv[p] = 1'b1;
        mask |= (1 << p);
      end
    end
    wait_got(mask);
    for (int p = 0; p < 2; p++) if (mask[p]) begin
      chk(got[p], "R10 response seen", got[p], 1);
      chk(gdata[p] == mkword(bk[p], w, LW'(off[p] >> 4)) && !gerr[p],
          "R2/R7 routed word", gdata[p], mkword(bk[p], w, LW'(off[p] >> 4)));
      chk(lat[p] == LAT, "R10 latency", lat[p], LAT);
    end
    if (mask == 3 && bk[0] != bk[1]) begin
      chk(acc_cyc[0] == acc_cyc[1], "R3 parallel accept", acc_cyc[1], acc_cyc[0]);
      ptr[bk[0]] = 1; ptr[bk[1]] = 0;
    end else if (mask == 3) begin
      int win, los;
      win = ptr[bk[0]]; los = 1 - win;
      chk(acc_cyc[win] < acc_cyc[los], "R5 round-robin winner", win, ptr[bk[0]]);
      chk(acc_cyc[los] - acc_cyc[win] == LAT + 2, "R4 serialized gap",
          acc_cyc[los] - acc_cyc[win], LAT + 2);
      ptr[bk[0]] = win;
    end else begin
      int p;
      p = mask[1] ? 1 : 0;
      ptr[bk[p]] = 1 - p;
    end
    @(posedge clk); #1;
  endtask

  initial begin
    hv = '0; ha = '0;
    for (int p = 0; p < 2; p++) begin drop[p] = 0; got[p] = 0; accepted[p] = 0; end
    for (int b = 0; b < 3; b++) ptr[b] = 0;
    repeat (2) @(negedge clk);
    chk(rv == 0 && bv == 0 && n_rv == 0, "R1 in reset", {rv, bv}, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(rv == 0 && bv == 0 && n_bv == 0, "R1 after reset", {rv, bv}, 0);
    @(posedge clk); #1;

    // sweep of all region pairings and word positions
    for (int s = 0; s < 4; s++)
      for (int r0 = 0; r0 < 4; r0++)
        for (int r1 = 0; r1 < 4; r1++)
          if (!(r0 == 3 && r1 == 3)) run_case(r0, r1, s + r0 * 4 + r1 * 16, (s + r0 + r1) & 3);

    // R6: bank 0 holds ready low for 3 cycles
    begin
      stall[0] = 3; accepted[1] = 0; got[1] = 0;
      ha[1] = AW'(32'h000120 | 32'h8); hv[1] = 1'b1;
      @(negedge clk); @(negedge clk);
      chk(bv[0] && bl[0] == LW'(32'h12), "R6 request held", bl[0], 32'h12);
      wait_got(2);
      chk(lat[1] == LAT + 3, "R6 stalled latency", lat[1], LAT + 3);
      chk(gdata[1] == mkword(0, 2, LW'(32'h12)), "R6 stalled data", gdata[1], mkword(0, 2, LW'(32'h12)));
      ptr[0] = 0;
      @(posedge clk); #1;
    end

    // R8: second request while one is outstanding
    begin
      int low;
      accepted[0] = 0; got[0] = 0;
      ha[0] = AW'(32'h000040); hv[0] = 1'b1;
      while (!accepted[0]) @(negedge clk);
      @(posedge clk); #2;
      ha[0] = AW'(32'h400084); hv[0] = 1'b1;
      low = 1;
      while (!got[0]) begin @(negedge clk); if (!got[0] && hr[0]) low = 0; end
      chk(low == 1, "R8 ready low while pending", low, 1);
      got[0] = 0;
      wait_got(1);
      chk(gdata[0] == mkword(2, 1, LW'(32'h8)), "R8 follow-on data", gdata[0], mkword(2, 1, LW'(32'h8)));
      ptr[0] = 1; ptr[2] = 1;
      @(posedge clk); #1;
    end

    // R9: data bank absent in the second instance
    for (int p = 0; p < 2; p++) begin
      accepted[p] = 0; got[p] = 0;
      ha[p] = AW'(32'h800000 + p * 32'h100 + 32'h24); hv[p] = 1'b1;
      @(negedge clk);
      chk(n_hr[p] == 1'b1, "R9 immediate accept", n_hr[p], 1);
      @(negedge clk);
      chk(n_rv[p] && n_re[p] && n_rd[p] == 0, "R9 error response", {n_rv[p], n_re[p], n_rd[p]}, 64'h3_00000000);
      @(negedge clk);
      chk(!n_rv[p], "R9 single response", n_rv[p], 0);
      wait_got(1 << p);
      chk(gdata[p] == mkword(1, 1, LW'((p * 32'h100 + 32'h24) >> 4)) && !gerr[p],
          "R9 present bank normal", gdata[p], mkword(1, 1, LW'((p * 32'h100 + 32'h24) >> 4)));
      @(posedge clk); #1;
    end
    chk(nd_bank1_seen == 0, "R9 bank 1 silent", nd_bank1_seen, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule